// File: doc/BRIEF.md
# Overcurrent Set-Point Sample-and-Hold

This block digitizes the overcurrent trip level of a buck converter once per enable cycle. When the start-up sequencer asks for a sample, a counter ramps from zero by one code per clock. The counter drives an external DAC, and an external comparator checks the DAC against the voltage that a programming resistor develops at the low-side gate pin. While the ramp runs, the block forces the low-side drive off, so that the pin carries only the programming current.

The first code at which the comparator reports that the DAC is above the pin voltage becomes the held set point. If the ramp reaches full scale without the comparator flipping, full scale is held and a saturation flag is raised. The held code persists until a new sample completes. A new sample can only begin after the enable has been dropped and raised again.

While a set point is held, the block compares a sensed-current code against it and reports a trip when the sensed code is strictly larger.

Top module: `ocp_setpoint_top`

## Requirements
- R1: While `rst_n` is low, and immediately after it rises, `done_o`, `sat_o` and `trip_o` are 0, `setpoint_o` and `dac_code_o` are 0, and `ldrv_off_o` is 0.
- R2: A `start_i` pulse begins a sample only when `enable_i` is high and no sample is held or running. A start given while `enable_i` is low leaves `ldrv_off_o` and `done_o` at 0.
- R3: In the cycle after an accepted start, `ldrv_off_o` goes to 1 and `dac_code_o` is 0. `dac_code_o` then rises by exactly 1 each cycle, and `ldrv_off_o` stays at 1 for the whole sampling window and is 0 outside it.
- R4: When `cmp_above_i` is 1 during sampling while `dac_code_o` equals C, the next cycle shows `done_o`=1, `setpoint_o`=C, `sat_o`=0 and `ldrv_off_o`=0.
- R5: When `dac_code_o` reaches 2^W-1 with `cmp_above_i` still 0, the next cycle shows `done_o`=1, `setpoint_o`=2^W-1 and `sat_o`=1. The window then lasts 2^W cycles.
- R6: A `start_i` pulse while `done_o` is 1 is ignored: `ldrv_off_o` stays 0 and `setpoint_o` is unchanged.
- R7: Dropping `enable_i` clears `done_o` and `ldrv_off_o` on the next edge and aborts any running sample. `setpoint_o` keeps its last held value until a later sample completes.
- R8: `trip_o` is 1 exactly when `done_o` is 1 and `sense_code_i` is strictly greater than `setpoint_o`. An equal code does not trip.
- R9: `sat_o` clears when a new sample is accepted, and stays 0 if that sample ends by comparator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| enable_i | input | 1 | Converter enable; low means shutdown |
| start_i | input | 1 | Sample request from the sequencer |
| cmp_above_i | input | 1 | Comparator: DAC output is above the pin voltage |
| sense_code_i | input | W | Sensed-current code for the runtime trip check |
| dac_code_o | output | W | Ramp code driving the external DAC |
| ldrv_off_o | output | 1 | Forces the low-side drive off during sampling |
| done_o | output | 1 | A set point is held and valid |
| setpoint_o | output | W | Held overcurrent set point |
| sat_o | output | 1 | Ramp hit full scale without a comparator flip |
| trip_o | output | 1 | Overcurrent trip |

## Verification
The bench models the comparator as `dac_code_o > level` and sweeps the level across the range, including 0, 2^W-2 and 2^W-1. These cases separate a correct end of ramp from an off-by-one set point, from a window that is too long or too short, and from a counter that wraps to zero instead of saturating. It also gives starts while disabled and while a set point is held, and drops the enable in the middle of a ramp. A design that restarted wrongly would glitch the low-side drive off or lose the held code. Trip is checked on both sides of the set point and at equality, which catches a comparison that is not strict or that is not gated by `done_o`.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_HOLD   = 2'd2
    } samp_state_e;
endpackage

// File: rtl/ocp_sample_fsm.sv
module ocp_sample_fsm
    import ocp_pkg::*;
#(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable_i,
    input  logic         start_i,
    input  logic         cmp_above_i,
    output logic [W-1:0] cnt_o,
    output logic         sampling_o,
    output logic         done_o,
    output logic [W-1:0] setpoint_o,
    output logic         sat_o
);
    localparam logic [W-1:0] CODE_MAX = {W{1'b1}};

    typedef struct packed {
        samp_state_e  state;
        logic [W-1:0] cnt;
        logic [W-1:0] setpoint;
        logic         done;
        logic         sat;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!enable_i) begin
            r_d.state = ST_IDLE;
            r_d.cnt   = '0;
            r_d.done  = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (start_i) begin
                        r_d.state = ST_SAMPLE;
                        r_d.cnt   = '0;
                        r_d.done  = 1'b0;
                        r_d.sat   = 1'b0;
                    end
                end
                ST_SAMPLE: begin
                    if (cmp_above_i) begin
                        r_d.setpoint = r_q.cnt;
                        r_d.done     = 1'b1;
                        r_d.state    = ST_HOLD;
                    end else if (r_q.cnt == CODE_MAX) begin
                        r_d.setpoint = CODE_MAX;
                        r_d.sat      = 1'b1;
                        r_d.done     = 1'b1;
                        r_d.state    = ST_HOLD;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_HOLD: begin
                    r_d.state = ST_HOLD;
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, cnt: '0, setpoint: '0, done: 1'b0, sat: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cnt_o      = r_q.cnt;
    assign sampling_o = (r_q.state == ST_SAMPLE);
    assign done_o     = r_q.done;
    assign setpoint_o = r_q.setpoint;
    assign sat_o      = r_q.sat;

    // R3: ramp advances one code per cycle while the comparator stays low
    a_r3_ramp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (sampling_o && enable_i && !cmp_above_i && r_q.cnt != CODE_MAX)
            |=> (r_q.cnt == $past(r_q.cnt) + 1'b1));

    // R2: a sampling window opens only after an enabled start
    a_r2_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sampling_o) |-> $past(start_i && enable_i));

    // R6: the held code does not move while a set point is held
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> $stable(r_q.setpoint));

    // R5: saturation always leaves full scale as the set point
    a_r5_sat_max: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_o) |-> (r_q.setpoint == CODE_MAX && done_o));
endmodule

// File: rtl/ocp_trip_cmp.sv
module ocp_trip_cmp #(
    parameter int W = 6
) (
    input  logic         armed_i,
    input  logic [W-1:0] sense_i,
    input  logic [W-1:0] limit_i,
    output logic         trip_o
);
    always_comb begin
        trip_o = armed_i && (sense_i > limit_i);
    end
endmodule

// File: rtl/ocp_setpoint_top.sv
module ocp_setpoint_top #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable_i,
    input  logic         start_i,
    input  logic         cmp_above_i,
    input  logic [W-1:0] sense_code_i,
    output logic [W-1:0] dac_code_o,
    output logic         ldrv_off_o,
    output logic         done_o,
    output logic [W-1:0] setpoint_o,
    output logic         sat_o,
    output logic         trip_o
);
    logic sampling;

    ocp_sample_fsm #(.W(W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable_i),
        .start_i     (start_i),
        .cmp_above_i (cmp_above_i),
        .cnt_o       (dac_code_o),
        .sampling_o  (sampling),
        .done_o      (done_o),
        .setpoint_o  (setpoint_o),
        .sat_o       (sat_o)
    );

    ocp_trip_cmp #(.W(W)) u_trip (
        .armed_i (done_o),
        .sense_i (sense_code_i),
        .limit_i (setpoint_o),
        .trip_o  (trip_o)
    );

    assign ldrv_off_o = sampling;

    // R8: no trip without a held set point
    a_r8_trip_armed: assert property (@(posedge clk) disable iff (!rst_n)
        trip_o |-> done_o);

    // R3: drive is never forced off while a set point is held
    a_r3_drive_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ldrv_off_o && done_o));

    // R7: a shutdown clears done and the drive override on the next edge
    a_r7_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (!done_o && !ldrv_off_o));
endmodule

// File: tb/ocp_setpoint_top_bench.sv
module ocp_setpoint_top_bench;
    localparam int W = 6;
    localparam int MAXC = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic start = 1'b0;
    logic cmp;
    logic [W-1:0] sense = '0;
    logic [W-1:0] dac_code, setpoint;
    logic ldrv_off, done, sat, trip;
    int level = 0;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    assign cmp = (int'(dac_code) > level);

    ocp_setpoint_top #(.W(W)) u_ocp_setpoint_top (
        .clk(clk), .rst_n(rst_n), .enable_i(enable), .start_i(start),
        .cmp_above_i(cmp), .sense_code_i(sense), .dac_code_o(dac_code),
        .ldrv_off_o(ldrv_off), .done_o(done), .setpoint_o(setpoint),
        .sat_o(sat), .trip_o(trip)
    );

    function automatic int exp_sp(int p);
        return (p >= MAXC) ? MAXC : p + 1;
    endfunction
    function automatic int exp_len(int p);
        return (p >= MAXC) ? MAXC + 1 : p + 2;
    endfunction
    function automatic bit exp_trip(bit d, int s, int sp);
        return d && (s > sp);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rearm();
        enable = 1'b0;
        cyc(1);
        enable = 1'b1;
        cyc(1);
    endtask

    task automatic run_sample(int p);
        int idx = 0;
        bit ramp_ok = 1'b1;
        level = p;
        rearm();
        start = 1'b1;
        cyc(1);
        start = 1'b0;
        while (ldrv_off && idx < 200) begin
            if (int'(dac_code) != idx) ramp_ok = 1'b0;
            idx++;
            cyc(1);
        end
        chk(ramp_ok, "R3 ramp", idx, exp_len(p));
        chk(idx == exp_len(p), "R3 window", idx, exp_len(p));
        chk(done == 1'b1, "R4 done", done, 1);
        chk(int'(setpoint) == exp_sp(p), (p >= MAXC) ? "R5 setpoint" : "R4 setpoint",
            setpoint, exp_sp(p));
        chk(sat == (p >= MAXC), (p >= MAXC) ? "R5 sat" : "R9 sat", sat, int'(p >= MAXC));
    endtask

    task automatic chk_trip(int s);
        sense = s[W-1:0];
        #1;
        chk(trip == exp_trip(done, s, setpoint), "R8 trip", trip,
            exp_trip(done, s, setpoint));
    endtask

    initial begin
        void'($urandom(32'd4242));
        cyc(3);
        chk(!done && !sat && !trip && setpoint == 0 && dac_code == 0 && !ldrv_off,
            "R1 reset", {done, sat, trip, ldrv_off}, 0);
        rst_n = 1'b1;
        cyc(1);
        chk(!done && !ldrv_off && setpoint == 0, "R1 after reset", done, 0);

        // R2: start while disabled
        start = 1'b1;
        cyc(1);
        start = 1'b0;
        cyc(2);
        chk(!ldrv_off && !done, "R2 disabled start", ldrv_off, 0);

        run_sample(10);
        chk_trip(11);
        chk_trip(12);
        chk_trip(0);

        // R6: start while held
        start = 1'b1;
        cyc(1);
        start = 1'b0;
        chk(!ldrv_off, "R6 no window", ldrv_off, 0);
        cyc(2);
        chk(setpoint == 11 && done, "R6 held", setpoint, 11);

        // R7: shutdown keeps code, clears done and trip
        enable = 1'b0;
        cyc(1);
        chk(!done && setpoint == 11, "R7 shutdown", setpoint, 11);
        chk_trip(MAXC);

        run_sample(MAXC);
        run_sample(0);
        run_sample(MAXC - 1);
        chk_trip(MAXC);

        // R7: abort mid-ramp keeps previous code
        level = 40;
        rearm();
        start = 1'b1;
        cyc(1);
        start = 1'b0;
        cyc(5);
        enable = 1'b0;
        cyc(1);
        chk(!ldrv_off && !done && setpoint == MAXC, "R7 abort", setpoint, MAXC);

        for (int i = 0; i < 15; i++) begin
            int p = int'($urandom % (MAXC + 1));
            run_sample(p);
            for (int k = 0; k < 3; k++) chk_trip(int'($urandom % (MAXC + 1)));
            chk_trip(int'(setpoint));
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule